// File: doc/BRIEF.md
# Secure Side Security-Controller Register Bank

This block is the secure-world register bank of a system security controller. Software on the secure side uses it to program two global configuration values: a 2-bit non-secure-callable setting and a security-violation response setting. It also uses it to watch and acknowledge interrupt status from three families of protection hardware. These are the peripheral protection controllers, the memory protection controllers and the bus-master security controllers. Status lines from every controller are gathered into packed 32-bit words at fixed bit positions. Enable and clear lines go back out to each controller, and the master security controllers produce one combined interrupt.

The bank sits on a simple request port. A request is valid, write or read, a 12-bit byte address, a size code and 32-bit write data. There is no back-pressure. Every valid request is accepted in the cycle it is presented. A read returns its data on `rsp_valid`/`rsp_rdata` exactly one cycle later, and the requester must take it then. Only aligned full-word writes have an effect. Reads of any size return the addressed byte lanes.

The per-port access registers of the protection controllers are not part of this bank.

Top module: `sc_sec_bank`

## Requirements
- R1: A word write to offset 0x14 stores bits [1:0] of the data, which drive `nsc_cfg_o` and read back at 0x14 with all higher bits zero.
- R2: A word write to offset 0x10 stores the whole 32-bit value, which reads back at 0x10; `resp_cfg_o` follows bit 0 of the stored value.
- R3: A word write to offset 0x28 stores the data ANDed with the controller mask (0x00f000f3 with default parameters). Enable bit 0..1 drives `apb_ppc_en_o`, bit 4+i drives `apbx_ppc_en_o[i]` and bit 20+i drives `ahbx_ppc_en_o[i]`.
- R4: The peripheral-controller status word at 0x20 uses the same bit positions as R3. A bit takes the new level of its input one clock edge after that input changes.
- R5: A word write to 0x24 clears each status bit where the data ANDed with the mask is 1. It also raises the matching `*_ppc_clr_o` lines for exactly one cycle after the write edge. A status bit whose input stays steady remains cleared until the input changes again.
- R6: The memory-controller status word at 0x1c shows `mpc_stat_i[n]` at bit n and `mpcx_stat_i[n]` at bit 16+n, following the inputs by level.
- R7: The master-controller status word at 0x30 shows `msc_stat_i[n]` at bit 16+n. The enable word at 0x38 stores the full written value. `msc_irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R8: A word write to 0x34 raises `msc_clr_o[n]` for one cycle after the write edge when data bit 16+n is 1. Reading 0x34 returns zero.
- R9: A word write to 0x3c stores data bits 16+n, which drive `msc_ns_o[n]` and read back at the same positions of 0x3c.
- R10: A word write to 0x48 keeps only data bits [31:16], and only those bits read back. Offset 0x40 always reads zero.
- R11: A write is applied only when the size code is 2 (word) and addr[1:0] is 0. Size codes 0 (byte) and 1 (halfword), and unaligned word writes, change nothing.
- R12: A read accepted at an edge gives `rsp_valid` high for the following cycle. `rsp_rdata` is then the aligned word shifted right by 8*addr[1:0], masked to 8 bits for size 0 and 16 bits for size 1. `rsp_valid` is low after every cycle with no read.
- R13: Writes to the status offsets 0x1c, 0x20, 0x30 and 0x40 change nothing. The clear offsets and unmapped offsets read as zero.
- R14: After reset all stored configuration, enable, status and non-secure words read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| resp_cfg_o | output | 1 | Violation-response setting |
| nsc_cfg_o | output | 2 | Non-secure-callable setting |
| apb_ppc_stat_i | input | 2 | Internal peripheral controller status |
| apbx_ppc_stat_i | input | NAX | Expansion peripheral-bus controller status |
| ahbx_ppc_stat_i | input | NHX | Expansion system-bus controller status |
| apb_ppc_en_o | output | 2 | Internal controller interrupt enables |
| apbx_ppc_en_o | output | NAX | Expansion peripheral-bus controller enables |
| ahbx_ppc_en_o | output | NHX | Expansion system-bus controller enables |
| apb_ppc_clr_o | output | 2 | Internal controller clear pulses |
| apbx_ppc_clr_o | output | NAX | Expansion peripheral-bus controller clear pulses |
| ahbx_ppc_clr_o | output | NHX | Expansion system-bus controller clear pulses |
| mpc_stat_i | input | NMPC | Internal memory controller status |
| mpcx_stat_i | input | NMPCX | Expansion memory controller status |
| msc_stat_i | input | NMSC | Master security controller status |
| msc_clr_o | output | NMSC | Master controller clear pulses |
| msc_ns_o | output | NMSC | Master controller non-secure settings |
| msc_irq_o | output | 1 | Combined master-controller interrupt |

## Verification
The peripheral-controller words are driven with the full mask, a sparse mix spread across all three groups, and single-group inputs. This shows whether each group lands at its own base bit and whether bits outside the mask are dropped. Clear writes are tried both with a status input held steady and after the input toggles, which separates a sticky clear from a level copy. Sub-word reads at every byte lane of a known word expose shift and truncation faults, and sub-word or unaligned writes show whether the word-only rule holds. The master interrupt is tried with matching and non-matching enables, which separates an AND of status and enable from either one alone.

// File: rtl/sc_sec_pkg.sv
package sc_sec_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_RESP     = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_NSC      = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_MPC_STAT = 12'h01c;
  localparam logic [ADDR_W-1:0] OFF_PPC_STAT = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_PPC_CLR  = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_PPC_EN   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_MSC_STAT = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_MSC_CLR  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_MSC_EN   = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_MSC_NS   = 12'h03c;
  localparam logic [ADDR_W-1:0] OFF_BRG_STAT = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_BRG_EN   = 12'h048;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int PPC_APB_N     = 2;
  localparam int PPC_APBX_BASE = 4;
  localparam int PPC_AHBX_BASE = 20;
  localparam int MPCX_BASE     = 16;
  localparam int MSC_BASE      = 16;

  function automatic logic [DATA_W-1:0] ppc_mask(int nax, int nhx);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < PPC_APB_N; i++) m[i] = 1'b1;
    for (int i = 0; i < nax; i++) m[PPC_APBX_BASE + i] = 1'b1;
    for (int i = 0; i < nhx; i++) m[PPC_AHBX_BASE + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sc_ppc_irq_ctl.sv
module sc_ppc_irq_ctl
  import sc_sec_pkg::*;
#(
  parameter int NAX = 4,
  parameter int NHX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        apb_src_i,
  input  logic [NAX-1:0]    apbx_src_i,
  input  logic [NHX-1:0]    ahbx_src_i,
  input  logic              clr_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] en_o,
  output logic [1:0]        apb_clr_o,
  output logic [NAX-1:0]    apbx_clr_o,
  output logic [NHX-1:0]    ahbx_clr_o
);
  localparam logic [DATA_W-1:0] MASK = ppc_mask(NAX, NHX);

  logic [DATA_W-1:0] src_w, src_q, chg_w, clr_w, stat_d;

  always_comb begin
    src_w = '0;
    src_w[PPC_APB_N-1:0] = apb_src_i;
    src_w[PPC_APBX_BASE +: NAX] = apbx_src_i;
    src_w[PPC_AHBX_BASE +: NHX] = ahbx_src_i;
    chg_w  = src_w ^ src_q;
    clr_w  = clr_wr_i ? (wdata_i & MASK) : '0;
    // an input transition in the same cycle overrides a software clear
    stat_d = ((stat_o & ~clr_w) & ~chg_w) | (src_w & chg_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      stat_o     <= '0;
      en_o       <= '0;
      apb_clr_o  <= '0;
      apbx_clr_o <= '0;
      ahbx_clr_o <= '0;
    end else begin
      src_q      <= src_w;
      stat_o     <= stat_d;
      if (en_wr_i) en_o <= wdata_i & MASK;
      apb_clr_o  <= clr_w[PPC_APB_N-1:0];
      apbx_clr_o <= clr_w[PPC_APBX_BASE +: NAX];
      ahbx_clr_o <= clr_w[PPC_AHBX_BASE +: NHX];
    end
  end
endmodule

// File: rtl/sc_msc_ctl.sv
module sc_msc_ctl
  import sc_sec_pkg::*;
#(
  parameter int NMSC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMSC-1:0]   msc_stat_i,
  input  logic              clr_wr_i,
  input  logic              en_wr_i,
  input  logic              ns_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_word_o,
  output logic [DATA_W-1:0] en_word_o,
  output logic [DATA_W-1:0] ns_word_o,
  output logic [NMSC-1:0]   clr_o,
  output logic [NMSC-1:0]   ns_o,
  output logic              irq_o
);
  logic [NMSC-1:0] clr_q, ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_word_o <= '0;
      clr_q     <= '0;
      ns_q      <= '0;
    end else begin
      if (en_wr_i) en_word_o <= wdata_i;
      if (ns_wr_i) ns_q <= wdata_i[MSC_BASE +: NMSC];
      clr_q <= clr_wr_i ? wdata_i[MSC_BASE +: NMSC] : '0;
    end
  end

  for (genvar n = 0; n < NMSC; n++) begin : g_port
    assign clr_o[n] = clr_q[n];
    assign ns_o[n]  = ns_q[n];
  end

  always_comb begin
    stat_word_o = '0;
    stat_word_o[MSC_BASE +: NMSC] = msc_stat_i;
    ns_word_o = '0;
    ns_word_o[MSC_BASE +: NMSC] = ns_q;
  end

  assign irq_o = |(stat_word_o & en_word_o);
endmodule

// File: rtl/sc_sec_rdmux.sv
module sc_sec_rdmux
  import sc_sec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] resp_w,
  input  logic [DATA_W-1:0] nsc_w,
  input  logic [DATA_W-1:0] mpc_w,
  input  logic [DATA_W-1:0] ppc_stat_w,
  input  logic [DATA_W-1:0] ppc_en_w,
  input  logic [DATA_W-1:0] msc_stat_w,
  input  logic [DATA_W-1:0] msc_en_w,
  input  logic [DATA_W-1:0] msc_ns_w,
  input  logic [DATA_W-1:0] brg_en_w,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word, shifted;

  always_comb begin
    word_addr = {addr_i[ADDR_W-1:2], 2'b00};
    unique case (word_addr)
      OFF_RESP:     word = resp_w;
      OFF_NSC:      word = nsc_w;
      OFF_MPC_STAT: word = mpc_w;
      OFF_PPC_STAT: word = ppc_stat_w;
      OFF_PPC_EN:   word = ppc_en_w;
      OFF_MSC_STAT: word = msc_stat_w;
      OFF_MSC_EN:   word = msc_en_w;
      OFF_MSC_NS:   word = msc_ns_w;
      OFF_BRG_EN:   word = brg_en_w;
      default:      word = '0;
    endcase
    shifted = word >> {addr_i[1:0], 3'b000};
    unique case (size_i)
      SZ_BYTE: data_o = {24'b0, shifted[7:0]};
      SZ_HALF: data_o = {16'b0, shifted[15:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/sc_sec_bank.sv
module sc_sec_bank
  import sc_sec_pkg::*;
#(
  parameter int NAX   = 4,
  parameter int NHX   = 4,
  parameter int NMPC  = 1,
  parameter int NMPCX = 4,
  parameter int NMSC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              resp_cfg_o,
  output logic [1:0]        nsc_cfg_o,
  input  logic [1:0]        apb_ppc_stat_i,
  input  logic [NAX-1:0]    apbx_ppc_stat_i,
  input  logic [NHX-1:0]    ahbx_ppc_stat_i,
  output logic [1:0]        apb_ppc_en_o,
  output logic [NAX-1:0]    apbx_ppc_en_o,
  output logic [NHX-1:0]    ahbx_ppc_en_o,
  output logic [1:0]        apb_ppc_clr_o,
  output logic [NAX-1:0]    apbx_ppc_clr_o,
  output logic [NHX-1:0]    ahbx_ppc_clr_o,
  input  logic [NMPC-1:0]   mpc_stat_i,
  input  logic [NMPCX-1:0]  mpcx_stat_i,
  input  logic [NMSC-1:0]   msc_stat_i,
  output logic [NMSC-1:0]   msc_clr_o,
  output logic [NMSC-1:0]   msc_ns_o,
  output logic              msc_irq_o
);
  localparam int BRG_W = DATA_W / 2;

  logic              wr_ok;
  logic [DATA_W-1:0] resp_q;
  logic [1:0]        nsc_q;
  logic [BRG_W-1:0]  brg_q;
  logic [DATA_W-1:0] ppc_stat, ppc_en, msc_stat, msc_en, msc_ns, mpc_word, rd_data;

  assign wr_ok = req_valid && req_write && (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q    <= '0;
      nsc_q     <= '0;
      brg_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_ok && req_addr == OFF_RESP)   resp_q <= req_wdata;
      if (wr_ok && req_addr == OFF_NSC)    nsc_q  <= req_wdata[1:0];
      if (wr_ok && req_addr == OFF_BRG_EN) brg_q  <= req_wdata[DATA_W-1:BRG_W];
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_data;
    end
  end

  assign resp_cfg_o = resp_q[0];
  assign nsc_cfg_o  = nsc_q;

  always_comb begin
    mpc_word = '0;
    mpc_word[NMPC-1:0] = mpc_stat_i;
    mpc_word[MPCX_BASE +: NMPCX] = mpcx_stat_i;
  end

  sc_ppc_irq_ctl #(.NAX(NAX), .NHX(NHX)) i_ppc (
    .clk        (clk),
    .rst_n      (rst_n),
    .apb_src_i  (apb_ppc_stat_i),
    .apbx_src_i (apbx_ppc_stat_i),
    .ahbx_src_i (ahbx_ppc_stat_i),
    .clr_wr_i   (wr_ok && req_addr == OFF_PPC_CLR),
    .en_wr_i    (wr_ok && req_addr == OFF_PPC_EN),
    .wdata_i    (req_wdata),
    .stat_o     (ppc_stat),
    .en_o       (ppc_en),
    .apb_clr_o  (apb_ppc_clr_o),
    .apbx_clr_o (apbx_ppc_clr_o),
    .ahbx_clr_o (ahbx_ppc_clr_o)
  );

  assign apb_ppc_en_o  = ppc_en[PPC_APB_N-1:0];
  assign apbx_ppc_en_o = ppc_en[PPC_APBX_BASE +: NAX];
  assign ahbx_ppc_en_o = ppc_en[PPC_AHBX_BASE +: NHX];

  sc_msc_ctl #(.NMSC(NMSC)) i_msc (
    .clk         (clk),
    .rst_n       (rst_n),
    .msc_stat_i  (msc_stat_i),
    .clr_wr_i    (wr_ok && req_addr == OFF_MSC_CLR),
    .en_wr_i     (wr_ok && req_addr == OFF_MSC_EN),
    .ns_wr_i     (wr_ok && req_addr == OFF_MSC_NS),
    .wdata_i     (req_wdata),
    .stat_word_o (msc_stat),
    .en_word_o   (msc_en),
    .ns_word_o   (msc_ns),
    .clr_o       (msc_clr_o),
    .ns_o        (msc_ns_o),
    .irq_o       (msc_irq_o)
  );

  sc_sec_rdmux i_rdmux (
    .addr_i     (req_addr),
    .size_i     (req_size),
    .resp_w     (resp_q),
    .nsc_w      ({30'b0, nsc_q}),
    .mpc_w      (mpc_word),
    .ppc_stat_w (ppc_stat),
    .ppc_en_w   (ppc_en),
    .msc_stat_w (msc_stat),
    .msc_en_w   (msc_en),
    .msc_ns_w   (msc_ns),
    .brg_en_w   ({brg_q, {BRG_W{1'b0}}}),
    .data_o     (rd_data)
  );
endmodule

// File: rtl/sc_sec_bank_chk.sv
module sc_sec_bank_chk
  import sc_sec_pkg::*;
#(
  parameter int NMSC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [11:0]     req_addr,
  input logic [1:0]      req_size,
  input logic            rsp_valid,
  input logic [31:0]     rsp_rdata,
  input logic [1:0]      nsc_cfg_o,
  input logic [1:0]      apb_ppc_en_o,
  input logic [1:0]      apb_ppc_clr_o,
  input logic [NMSC-1:0] msc_stat_i,
  input logic [NMSC-1:0] msc_clr_o,
  input logic            msc_irq_o
);
  p_nsc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_size == SZ_WORD && req_addr == OFF_NSC) |=> $stable(nsc_cfg_o))
    else $error("p_nsc_hold_r1");

  p_ppc_clr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|apb_ppc_clr_o) |-> $past(req_valid && req_write && req_addr == OFF_PPC_CLR))
    else $error("p_ppc_clr_src_r5");

  p_msc_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msc_irq_o |-> (|msc_stat_i))
    else $error("p_msc_irq_src_r7");

  p_msc_clr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|msc_clr_o) |-> $past(req_valid && req_write && req_addr == OFF_MSC_CLR))
    else $error("p_msc_clr_src_r8");

  p_brg_stat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr[11:2]) == OFF_BRG_STAT[11:2]) |-> rsp_rdata == 32'h0)
    else $error("p_brg_stat_zero_r10");

  p_subword_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != SZ_WORD) |=> ($stable(nsc_cfg_o) && $stable(apb_ppc_en_o)))
    else $error("p_subword_wr_r11");

  p_rsp_after_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid)
    else $error("p_rsp_after_rd_r12");

  p_no_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid)
    else $error("p_no_rsp_r12");
endmodule

bind sc_sec_bank sc_sec_bank_chk #(.NMSC(NMSC)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .nsc_cfg_o     (nsc_cfg_o),
  .apb_ppc_en_o  (apb_ppc_en_o),
  .apb_ppc_clr_o (apb_ppc_clr_o),
  .msc_stat_i    (msc_stat_i),
  .msc_clr_o     (msc_clr_o),
  .msc_irq_o     (msc_irq_o)
);

// File: tb/test_sc_sec_bank.sv
module test_sc_sec_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        resp_cfg_o;
  logic [1:0]  nsc_cfg_o;
  logic [1:0]  apb_ppc_stat_i = '0;
  logic [3:0]  apbx_ppc_stat_i = '0, ahbx_ppc_stat_i = '0;
  logic [1:0]  apb_ppc_en_o, apb_ppc_clr_o;
  logic [3:0]  apbx_ppc_en_o, ahbx_ppc_en_o, apbx_ppc_clr_o, ahbx_ppc_clr_o;
  logic [0:0]  mpc_stat_i = '0;
  logic [3:0]  mpcx_stat_i = '0, msc_stat_i = '0;
  logic [3:0]  msc_clr_o, msc_ns_o;
  logic        msc_irq_o;

  int checks = 0, failures = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_sec_bank i_sc_sec_bank (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdw(logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    rdw(12'h010, rd); chk("R14 resp", rd, 0);
    rdw(12'h014, rd); chk("R14 nsc", rd, 0);
    rdw(12'h028, rd); chk("R14 ppc_en", rd, 0);
    rdw(12'h03c, rd); chk("R14 msc_ns", rd, 0);
    chk("R14 outputs", {resp_cfg_o, nsc_cfg_o, apb_ppc_en_o, msc_irq_o, msc_ns_o}, 0);
  endtask

  task automatic t_cfg();
    wr(12'h014, 32'hFFFF_FFFE);
    chk("R12 no rsp after write", {31'b0, rsp_valid}, 0);
    chk("R1 nsc_cfg_o", {30'b0, nsc_cfg_o}, 2);
    rdw(12'h014, rd); chk("R1 readback", rd, 2);
    wr(12'h010, 32'h1234_5671);
    chk("R2 resp_cfg_o", {31'b0, resp_cfg_o}, 1);
    rdw(12'h010, rd); chk("R2 readback", rd, 32'h1234_5671);
  endtask

  task automatic t_ppc_en();
    wr(12'h028, 32'hFFFF_FFFF);
    rdw(12'h028, rd); chk("R3 full mask", rd, 32'h00f0_00f3);
    wr(12'h028, 32'h0050_0021);
    rdw(12'h028, rd); chk("R3 sparse", rd, 32'h0050_0021);
    chk("R3 apb en", {30'b0, apb_ppc_en_o}, 32'h1);
    chk("R3 apbx en", {28'b0, apbx_ppc_en_o}, 32'h2);
    chk("R3 ahbx en", {28'b0, ahbx_ppc_en_o}, 32'h5);
  endtask

  task automatic t_ppc_stat_clr();
    apb_ppc_stat_i = 2'b10; apbx_ppc_stat_i = 4'b1000; ahbx_ppc_stat_i = 4'b0001;
    repeat (2) @(negedge clk);
    rdw(12'h020, rd); chk("R4 status", rd, 32'h0010_0082);
    wr(12'h020, 32'h0);
    rdw(12'h020, rd); chk("R13 status write ignored", rd, 32'h0010_0082);
    wr(12'h024, 32'h0000_0082);
    chk("R5 apb clr pulse", {30'b0, apb_ppc_clr_o}, 2);
    chk("R5 apbx clr pulse", {28'b0, apbx_ppc_clr_o}, 8);
    chk("R5 ahbx clr pulse", {28'b0, ahbx_ppc_clr_o}, 0);
    @(negedge clk);
    chk("R5 clr one cycle", {apb_ppc_clr_o, apbx_ppc_clr_o}, 0);
    rdw(12'h020, rd); chk("R5 cleared sticky", rd, 32'h0010_0000);
    rdw(12'h024, rd); chk("R13 clr reads zero", rd, 0);
    apb_ppc_stat_i = 2'b00; @(negedge clk);
    apb_ppc_stat_i = 2'b10; repeat (2) @(negedge clk);
    rdw(12'h020, rd); chk("R4 retoggle sets", rd, 32'h0010_0002);
  endtask

  task automatic t_mpc();
    mpc_stat_i = 1'b1; mpcx_stat_i = 4'b0101; @(negedge clk);
    rdw(12'h01c, rd); chk("R6 mpc status", rd, 32'h0005_0001);
    mpc_stat_i = 1'b0; mpcx_stat_i = 4'b1000; @(negedge clk);
    rdw(12'h01c, rd); chk("R6 mpc level", rd, 32'h0008_0000);
  endtask

  task automatic t_msc();
    msc_stat_i = 4'b0010; @(negedge clk);
    chk("R7 irq off, enable 0", {31'b0, msc_irq_o}, 0);
    rdw(12'h030, rd); chk("R7 msc status", rd, 32'h0002_0000);
    wr(12'h038, 32'h0002_0000);
    chk("R7 irq on", {31'b0, msc_irq_o}, 1);
    wr(12'h038, 32'h0001_0000);
    chk("R7 irq mismatched enable", {31'b0, msc_irq_o}, 0);
    wr(12'h034, 32'h000A_0003);
    chk("R8 msc clr pulse", {28'b0, msc_clr_o}, 32'hA);
    @(negedge clk);
    chk("R8 msc clr one cycle", {28'b0, msc_clr_o}, 0);
    rdw(12'h034, rd); chk("R8 msc clr reads zero", rd, 0);
    wr(12'h03c, 32'hFFFF_FFFF);
    chk("R9 msc_ns_o", {28'b0, msc_ns_o}, 32'hF);
    rdw(12'h03c, rd); chk("R9 readback", rd, 32'h000F_0000);
  endtask

  task automatic t_brg_unmapped();
    wr(12'h048, 32'h1234_ABCD);
    rdw(12'h048, rd); chk("R10 bridge enable", rd, 32'h1234_0000);
    wr(12'h040, 32'hFFFF_FFFF);
    rdw(12'h040, rd); chk("R10 bridge status zero", rd, 0);
    rdw(12'h200, rd); chk("R13 unmapped zero", rd, 0);
  endtask

  task automatic t_subword();
    wr(12'h010, 32'h0, 2'd0);
    wr(12'h010, 32'h0, 2'd1);
    wr(12'h011, 32'h0, 2'd2);
    rdw(12'h010, rd); chk("R11 subword/unaligned write ignored", rd, 32'h1234_5671);
    rdw(12'h010, rd, 2'd0); chk("R12 byte lane 0", rd, 32'h71);
    rdw(12'h011, rd, 2'd0); chk("R12 byte lane 1", rd, 32'h56);
    rdw(12'h012, rd, 2'd1); chk("R12 half upper", rd, 32'h1234);
    rdw(12'h013, rd, 2'd0); chk("R12 byte lane 3", rd, 32'h12);
    @(negedge clk);
    chk("R12 idle no rsp", {31'b0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_ppc_en();
    t_ppc_stat_clr();
    t_mpc();
    t_msc();
    t_brg_unmapped();
    t_subword();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule